// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, once per clock, which hardware thread of a simultaneously multithreaded core drives the instruction fetch unit in the following cycle. It keeps three 6-bit event counters per thread: instructions held in the front, not-yet-issued part of the pipeline, unresolved branches in that region, and outstanding data-cache misses. Each counter moves on increment and decrement pulses that the pipeline sends.

A selectable heuristic turns the counters into a score per thread, and the lowest score wins. A thread's distance from the instruction-queue head can also serve as its priority. Ties go to the thread that comes first in round-robin order. An optional overwatch layer then looks at the miss counters. If the primary pick has clearly more outstanding misses than the best eligible thread, the overwatch replaces the pick. The grant is registered as a one-hot vector with a valid flag and a flag that shows an override.

The selection is held in a small registered state machine:
- ST_IDLE means no grant.
- ST_PRIMARY means the heuristic's own choice was granted.
- ST_OVERRIDE means the overwatch replaced that choice.

The state is re-evaluated on every clock edge from any state:
- It goes to ST_IDLE when no thread is eligible.
- It goes to ST_OVERRIDE when the override condition holds.
- It goes to ST_PRIMARY otherwise.

Top module: `smt_fetch_sel`

## Requirements
- R1: The outputs are registered. While any thread is eligible, `gnt_vld` is 1 and `gnt_oh` has exactly one bit set, bit i selecting thread i. When no thread is eligible, `gnt_vld`, `gnt_ovr` and `gnt_oh` are all 0 after the next edge. All three are 0 during reset.
- R2: A thread whose `thr_elig` bit is 0 is never granted.
- R3: Each counter is 6 bits wide, resets to 0, and behaves as follows. An up pulse alone adds 1, but the counter holds at 63. A down pulse alone subtracts 1, but the counter holds at 0. Up and down together leave it unchanged.
- R4: With `heur_sel` = 0, the score is the thread's front-end instruction count.
- R5: With `heur_sel` = 1, the score is the thread's unresolved-branch count.
- R6: With `heur_sel` = 2, the score is the thread's outstanding-miss count.
- R7: With `heur_sel` = 3, the score is `wt_br`*branch count + `wt_inst`*instruction count, using 3-bit unsigned weights.
- R8: With `heur_sel` = 4, the score is 15 − `q_depth` of the thread. A thread whose oldest instruction is nearest the queue head therefore has the lowest priority. Codes 5 to 7 act as code 0.
- R9: Among eligible threads, the lowest score wins. Equal scores are resolved by scanning from a round-robin pointer upward with wrap. The pointer resets to 0 and moves to the thread after each granted one.
- R10: When `ovw_en` is 1, the overwatch compares two miss counts: that of the primary pick, and that of the eligible thread with fewest misses (found with the same round-robin scan). If the first exceeds the second by at least `ovw_thr`, the minimum-miss thread is granted and `gnt_ovr` is 1. Otherwise `gnt_ovr` is 0.
- R11: A pulse present at clock edge k changes the counter at edge k, and that change first shows in the grant registered at edge k+1. Changes to eligibility, mode, weights, queue depth and overwatch inputs present at edge k already act on the grant registered at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_elig | input | NTHR | Per-thread eligible mask |
| inst_up | input | NTHR | Instruction entered front end |
| inst_dn | input | NTHR | Instruction left front end |
| br_up | input | NTHR | Branch fetched |
| br_dn | input | NTHR | Branch resolved |
| miss_up | input | NTHR | Data-cache miss started |
| miss_dn | input | NTHR | Data-cache miss returned |
| q_depth | input | NTHR×QW | Distance of each thread's oldest entry from queue head |
| heur_sel | input | 3 | Primary heuristic code |
| wt_br | input | WW | Branch weight for blended mode |
| wt_inst | input | WW | Instruction weight for blended mode |
| ovw_en | input | 1 | Enable miss-count overwatch |
| ovw_thr | input | CW | Overwatch override threshold |
| gnt_oh | output | NTHR | One-hot fetch grant |
| gnt_vld | output | 1 | Grant valid |
| gnt_ovr | output | 1 | Grant came from the overwatch |

## Verification
Each result has a fixed latency:
- A grant reflects eligibility and configuration presented before the same edge.
- Counter pulses show in the grant one edge later, after first being absorbed into the counters.

The bench model follows this exactly. For each cycle it computes the expected grant from its own counter values before applying that cycle's pulses, then advances its counters. It compares the registered outputs at the following falling edge. Directed phases cover round-robin rotation, an empty mask, counter saturation and cancellation. Randomized phases run each heuristic with and without the overwatch.

// File: rtl/smt_fetch_pkg.sv
`timescale 1ns/1ps
package smt_fetch_pkg;
    typedef enum logic [2:0] {
        HEUR_INST   = 3'd0,
        HEUR_BRANCH = 3'd1,
        HEUR_MISS   = 3'd2,
        HEUR_BLEND  = 3'd3,
        HEUR_QPOS   = 3'd4
    } heur_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PRIMARY  = 2'd1,
        ST_OVERRIDE = 2'd2
    } sel_state_e;
endpackage

// File: rtl/smt_evt_ctr.sv
`timescale 1ns/1ps
module smt_evt_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up,
    input  logic          dn,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (up && !dn && cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end else if (dn && !up && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_CTR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && up && !dn) |=> (cnt == CMAX)); // R3
    AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && dn && !up) |=> (cnt == '0)); // R3
    AST_CTR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> $stable(cnt)); // R3
endmodule

// File: rtl/smt_min_pick.sv
`timescale 1ns/1ps
module smt_min_pick #(
    parameter int N  = 4,
    parameter int SW = 10,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][SW-1:0] score,
    input  logic [N-1:0]         elig,
    input  logic [IW-1:0]        rr_ptr,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    logic [SW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int k = 0; k < N; k++) begin
            int t;
            t = int'(rr_ptr) + k;
            if (t >= N) t = t - N;
            if (elig[t] && (!found || score[t] < best)) begin
                found = 1'b1;
                idx   = IW'(t);
                best  = score[t];
            end
        end
    end
endmodule

// File: rtl/smt_fetch_sel.sv
`timescale 1ns/1ps
module smt_fetch_sel
    import smt_fetch_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int CW   = 6,
    parameter int WW   = 3,
    parameter int QW   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NTHR-1:0]           thr_elig,
    input  logic [NTHR-1:0]           inst_up,
    input  logic [NTHR-1:0]           inst_dn,
    input  logic [NTHR-1:0]           br_up,
    input  logic [NTHR-1:0]           br_dn,
    input  logic [NTHR-1:0]           miss_up,
    input  logic [NTHR-1:0]           miss_dn,
    input  logic [NTHR-1:0][QW-1:0]   q_depth,
    input  logic [2:0]                heur_sel,
    input  logic [WW-1:0]             wt_br,
    input  logic [WW-1:0]             wt_inst,
    input  logic                      ovw_en,
    input  logic [CW-1:0]             ovw_thr,
    output logic [NTHR-1:0]           gnt_oh,
    output logic                      gnt_vld,
    output logic                      gnt_ovr
);
    localparam int IW = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam int SW = CW + WW + 1;
    localparam logic [QW-1:0] QTOP = '1;

    logic [NTHR-1:0][CW-1:0] inst_cnt, br_cnt, miss_cnt;
    logic [NTHR-1:0][SW-1:0] pri_score;

    generate
        for (genvar t = 0; t < NTHR; t++) begin : g_thr
            smt_evt_ctr #(.CW(CW)) u_inst (
                .clk(clk), .rst_n(rst_n), .up(inst_up[t]), .dn(inst_dn[t]), .cnt(inst_cnt[t]));
            smt_evt_ctr #(.CW(CW)) u_br (
                .clk(clk), .rst_n(rst_n), .up(br_up[t]), .dn(br_dn[t]), .cnt(br_cnt[t]));
            smt_evt_ctr #(.CW(CW)) u_miss (
                .clk(clk), .rst_n(rst_n), .up(miss_up[t]), .dn(miss_dn[t]), .cnt(miss_cnt[t]));

            always_comb begin
                case (heur_e'(heur_sel))
                    HEUR_BRANCH: pri_score[t] = SW'(br_cnt[t]);
                    HEUR_MISS:   pri_score[t] = SW'(miss_cnt[t]);
                    HEUR_BLEND:  pri_score[t] = SW'(wt_br) * SW'(br_cnt[t])
                                              + SW'(wt_inst) * SW'(inst_cnt[t]);
                    HEUR_QPOS:   pri_score[t] = SW'(QTOP - q_depth[t]);
                    default:     pri_score[t] = SW'(inst_cnt[t]);
                endcase
            end
        end
    endgenerate

    sel_state_e    state, state_nx;
    logic [IW-1:0] gnt_idx, idx_nx, rr_ptr;
    logic          pri_found, ms_found, take_ovr;
    logic [IW-1:0] pri_idx, ms_idx;
    logic [CW-1:0] miss_gap;

    smt_min_pick #(.N(NTHR), .SW(SW), .IW(IW)) u_pri (
        .score(pri_score), .elig(thr_elig), .rr_ptr(rr_ptr),
        .found(pri_found), .idx(pri_idx));

    smt_min_pick #(.N(NTHR), .SW(CW), .IW(IW)) u_miss_pick (
        .score(miss_cnt), .elig(thr_elig), .rr_ptr(rr_ptr),
        .found(ms_found), .idx(ms_idx));

    always_comb begin
        miss_gap = miss_cnt[pri_idx] - miss_cnt[ms_idx];
        take_ovr = ovw_en && pri_found && ms_found && (miss_gap >= ovw_thr);
        if (!pri_found) begin
            state_nx = ST_IDLE;
            idx_nx   = '0;
        end else if (take_ovr) begin
            state_nx = ST_OVERRIDE;
            idx_nx   = ms_idx;
        end else begin
            state_nx = ST_PRIMARY;
            idx_nx   = pri_idx;
        end
    end

    // state register, grant index and round-robin pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            gnt_idx <= '0;
            rr_ptr  <= '0;
        end else begin
            state   <= state_nx;
            gnt_idx <= idx_nx;
            if (state_nx != ST_IDLE) begin
                rr_ptr <= (int'(idx_nx) == NTHR - 1) ? '0 : idx_nx + 1'b1;
            end
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        gnt_oh  = '0;
        gnt_vld = 1'b0;
        gnt_ovr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                gnt_vld = 1'b0;
            end
            ST_PRIMARY: begin
                gnt_oh[gnt_idx] = 1'b1;
                gnt_vld         = 1'b1;
            end
            ST_OVERRIDE: begin
                gnt_oh[gnt_idx] = 1'b1;
                gnt_vld         = 1'b1;
                gnt_ovr         = 1'b1;
            end
            default: begin
                gnt_vld = 1'b0;
            end
        endcase
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> ($countones(gnt_oh) == 1)); // R1
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld |-> (gnt_oh == '0 && !gnt_ovr)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|thr_elig) |=> gnt_vld); // R1
    AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !(|thr_elig) |=> !gnt_vld); // R1
    AST_ELIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> ((gnt_oh & ~$past(thr_elig)) == '0)); // R2
    AST_OVR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_ovr |-> $past(ovw_en)); // R10
endmodule

// File: tb/smt_fetch_sel_test.sv
`timescale 1ns/1ps
module smt_fetch_sel_test;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      thr_elig = '0;
    logic [3:0]      inst_up = '0, inst_dn = '0, br_up = '0, br_dn = '0, miss_up = '0, miss_dn = '0;
    logic [3:0][3:0] q_depth = '0;
    logic [2:0]      heur_sel = '0;
    logic [2:0]      wt_br = '0, wt_inst = '0;
    logic            ovw_en = 1'b0;
    logic [5:0]      ovw_thr = '0;
    logic [3:0]      gnt_oh;
    logic            gnt_vld, gnt_ovr;

    int n_chk = 0;
    int n_fail = 0;
    int ic[4], bc[4], mc[4];
    int rr = 0;

    always #4 clk = ~clk;

    smt_fetch_sel uut (
        .clk(clk), .rst_n(rst_n), .thr_elig(thr_elig),
        .inst_up(inst_up), .inst_dn(inst_dn), .br_up(br_up), .br_dn(br_dn),
        .miss_up(miss_up), .miss_dn(miss_dn), .q_depth(q_depth),
        .heur_sel(heur_sel), .wt_br(wt_br), .wt_inst(wt_inst),
        .ovw_en(ovw_en), .ovw_thr(ovw_thr),
        .gnt_oh(gnt_oh), .gnt_vld(gnt_vld), .gnt_ovr(gnt_ovr));

    function automatic int mpick(input int sc[4], input logic [3:0] el, input int start);
        int best = -1;
        int bv = 0;
        for (int k = 0; k < 4; k++) begin
            int t = (start + k) % 4;
            if (el[t] && (best < 0 || sc[t] < bv)) begin
                best = t;
                bv = sc[t];
            end
        end
        return best;
    endfunction

    function automatic int sat_step(input int c, input logic u, input logic d);
        if (u && !d && c < 63) return c + 1;
        if (d && !u && c > 0) return c - 1;
        return c;
    endfunction

    task automatic check(input string tag, input logic [3:0] eo, input logic ev, input logic eov);
        n_chk++;
        if (gnt_oh !== eo || gnt_vld !== ev || gnt_ovr !== eov) begin
            n_fail++;
            $display("FAIL %s: oh=%b vld=%b ovr=%b expected oh=%b vld=%b ovr=%b",
                     tag, gnt_oh, gnt_vld, gnt_ovr, eo, ev, eov);
        end
    endtask

    task automatic cycle(input string tag);
        int sc[4];
        int p, m, g;
        logic [3:0] eo;
        logic ev, eov;
        for (int t = 0; t < 4; t++) begin
            case (heur_sel)
                3'd1: sc[t] = bc[t];
                3'd2: sc[t] = mc[t];
                3'd3: sc[t] = int'(wt_br) * bc[t] + int'(wt_inst) * ic[t];
                3'd4: sc[t] = 15 - int'(q_depth[t]);
                default: sc[t] = ic[t];
            endcase
        end
        p = mpick(sc, thr_elig, rr);
        eo = '0; ev = 1'b0; eov = 1'b0;
        if (p >= 0) begin
            m = mpick(mc, thr_elig, rr);
            eov = ovw_en && ((mc[p] - mc[m]) >= int'(ovw_thr));
            g = eov ? m : p;
            eo = 4'b0001 << g;
            ev = 1'b1;
            rr = (g + 1) % 4;
        end
        for (int t = 0; t < 4; t++) begin
            ic[t] = sat_step(ic[t], inst_up[t], inst_dn[t]);
            bc[t] = sat_step(bc[t], br_up[t], br_dn[t]);
            mc[t] = sat_step(mc[t], miss_up[t], miss_dn[t]);
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, eo, ev, eov);
    endtask

    task automatic clear_pulses();
        inst_up = '0; inst_dn = '0; br_up = '0; br_dn = '0; miss_up = '0; miss_dn = '0;
    endtask

    task automatic rand_inputs(input logic rand_elig);
        for (int t = 0; t < 4; t++) begin
            inst_up[t] = ($urandom % 2) == 0;
            inst_dn[t] = ($urandom % 3) == 0;
            br_up[t]   = ($urandom % 3) == 0;
            br_dn[t]   = ($urandom % 4) == 0;
            miss_up[t] = ($urandom % 3) == 0;
            miss_dn[t] = ($urandom % 4) == 0;
            q_depth[t] = 4'($urandom);
        end
        if (rand_elig && ($urandom % 4) == 0) thr_elig = 4'($urandom);
        else thr_elig = 4'hF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int t = 0; t < 4; t++) begin ic[t] = 0; bc[t] = 0; mc[t] = 0; end
        thr_elig = 4'hF;
        repeat (2) @(negedge clk);
        check("R1 reset", 4'b0000, 1'b0, 1'b0);
        @(negedge clk);
        check("R1 reset", 4'b0000, 1'b0, 1'b0);
        rst_n = 1'b1;

        // round-robin rotation with equal scores
        for (int i = 0; i < 6; i++) cycle("R9");
        // empty mask
        thr_elig = 4'b0000;
        cycle("R1 empty");
        cycle("R1 empty");
        // partial mask
        thr_elig = 4'b0101;
        for (int i = 0; i < 4; i++) cycle("R2");
        thr_elig = 4'hF;

        // pulse presented at an edge acts one grant later
        inst_up = 4'b0001;
        cycle("R11");
        clear_pulses();
        cycle("R11");
        cycle("R11");

        // counter saturation at the top, cancellation and floor
        inst_up = 4'b0001;
        for (int i = 0; i < 70; i++) cycle("R3 ceiling");
        inst_dn = 4'b0001;
        for (int i = 0; i < 4; i++) cycle("R3 cancel");
        inst_up = 4'b0000;
        for (int i = 0; i < 70; i++) cycle("R3 floor");
        clear_pulses();
        cycle("R3");

        // each heuristic under random traffic
        for (int md = 0; md < 8; md++) begin
            heur_sel = 3'(md);
            for (int i = 0; i < 150; i++) begin
                rand_inputs(1'b1);
                wt_br = 3'($urandom);
                wt_inst = 3'($urandom);
                case (md)
                    1: cycle("R5");
                    2: cycle("R6");
                    3: cycle("R7");
                    4: cycle("R8");
                    default: cycle("R4");
                endcase
            end
        end

        // overwatch across heuristics and thresholds
        ovw_en = 1'b1;
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) begin
                heur_sel = 3'($urandom % 5);
                ovw_thr = 6'(1 + $urandom % 4);
            end
            rand_inputs(1'b1);
            wt_br = 3'($urandom);
            wt_inst = 3'($urandom);
            cycle("R10");
        end
        ovw_thr = '0;
        for (int i = 0; i < 20; i++) begin
            rand_inputs(1'b0);
            cycle("R10 zero threshold");
        end
        ovw_en = 1'b0;
        clear_pulses();
        cycle("R10 disabled");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule